// File: doc/BRIEF.md
# General-Purpose I/O Port with Grouped Interrupts

This block is a 32-line general-purpose I/O port controlled through a simple word-addressed register bus. Writes take effect at the clock edge that samples them. Reads return data on the cycle after the request.

Each line has three controls:
- a direction bit, which selects between driving the pad and listening to it;
- an output latch;
- a blink enable, which replaces the latch value with a shared, slowly toggling phase.

Incoming pad values pass through a two-flop synchronizer. They are then optionally inverted per line, and the corrected value forms the readable input word.

The input word feeds two interrupt paths. The level path uses the corrected input bits directly. The edge path latches every low-to-high transition of a corrected bit into a sticky cause register, which software clears by writing zeros. Each path has its own mask register. The masked contributions of every group of eight consecutive lines are ORed into one summary interrupt wire. The two mask registers can be relocated by a parameter so that the block fits an existing address layout.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `pin_oe` is all ones (every line drives), `pin_out` is all zeros and `irq_group` is all zeros.
- R2: Register byte offsets are: output latch 0x00, direction 0x04, blink enable 0x08, input inversion 0x0C, input word 0x10, edge cause 0x14. A read asserted at one clock edge presents its data on `bus_rdata` from that edge until the next read. Read-write registers return the last value written.
- R3: A direction bit of 1 makes the line an input with `pin_oe` low. A direction bit of 0 sets `pin_oe` high. With blink disabled, `pin_out` equals the output latch.
- R4: The input word is the pad value delayed by two clock edges, XORed with the inversion register. Writes to the input word have no effect.
- R5: A line with its blink bit set drives the shared blink phase on `pin_out`. The phase starts low after reset and inverts every `BLINK_HALF` clock cycles. Lines without the bit keep following their latch.
- R6: A 0-to-1 transition of a corrected input bit sets its edge cause bit. An inversion bit of 0 therefore captures rising pad edges, and an inversion bit of 1 captures falling pad edges.
- R7: Writing to the edge cause register clears each bit written as 0 and keeps each bit written as 1. A transition detected at the same edge as a clearing write leaves its bit set.
- R8: A line raises its group interrupt while its corrected input bit and its level mask bit are both 1.
- R9: `irq_group[g]` is the OR, over lines 8g to 8g+7, of (input AND level mask) OR (edge cause AND edge mask). It is low whenever both masks are zero.
- R10: The edge mask sits at 0x18 + `MASK_OFS` and the level mask at 0x1C + `MASK_OFS`. An address that maps to no register reads as zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Registered read data |
| pin_in | input | NLINES | Pad input values, asynchronous |
| pin_out | output | NLINES | Pad output values |
| pin_oe | output | NLINES | Pad driver enable, 1 = drive |
| irq_group | output | NLINES/8 | Summary interrupt per group of eight lines |

## Verification
The hardest case to reach from the ports is a pad transition that reaches the edge detector at exactly the clock edge where a clearing write lands. The stimulus changes the pad at a falling clock edge, waits two rising edges for the synchronizer, and issues the clearing write so that it is sampled at the third rising edge. The bit must survive that write. Polarity-selected falling-edge capture, and the relocated mask addresses, are reached by running the bench with a nonzero mask offset and with the upper half of the lines inverted.

// File: rtl/gpio_pkg.sv
// Shared constants for the GPIO port: nominal register byte offsets.
// Assumes a word-aligned byte address bus; mask registers are relocated by the top.
package gpio_pkg;
    localparam int unsigned OFS_OUT   = 'h00;
    localparam int unsigned OFS_DIR   = 'h04;
    localparam int unsigned OFS_BLINK = 'h08;
    localparam int unsigned OFS_INV   = 'h0C;
    localparam int unsigned OFS_DIN   = 'h10;
    localparam int unsigned OFS_CAUSE = 'h14;
    localparam int unsigned OFS_EMASK = 'h18;
    localparam int unsigned OFS_LMASK = 'h1C;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is promised.
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Two-stage capture of the pad values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_blink.sv
// Free-running blink phase generator shared by every line.
// The phase starts low after reset and inverts every HALF clock cycles.
// Assumes HALF >= 1.
module gpio_blink #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CNT_W = $clog2(HALF + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    // Count one half-period and invert the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
// Interrupt logic: sticky rising-transition cause register plus a
// per-group OR of the masked level and edge contributions.
// Assumes NLINES is a multiple of GROUP. A detected transition wins over
// a clearing write that lands at the same edge.
module gpio_irq_unit #(
    parameter int NLINES = 32,
    parameter int GROUP  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NLINES-1:0]         din,
    input  logic [NLINES-1:0]         level_mask,
    input  logic [NLINES-1:0]         edge_mask,
    input  logic                      cause_wr,
    input  logic [NLINES-1:0]         cause_wdata,
    output logic [NLINES-1:0]         cause,
    output logic [NLINES/GROUP-1:0]   irq_group
);
    localparam int NGROUPS = NLINES / GROUP;

    logic [NLINES-1:0] din_prev;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] hit;

    // Transition detection on the corrected input.
    always_comb rise = din & ~din_prev;

    // Masked contribution of each line.
    always_comb hit = (din & level_mask) | (cause & edge_mask);

    // Track the previous input and update the sticky cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_prev <= '0;
            cause    <= '0;
        end else begin
            din_prev <= din;
            if (cause_wr) cause <= (cause & cause_wdata) | rise;
            else          cause <= cause | rise;
        end
    end

    // One summary output per group of consecutive lines.
    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        assign irq_group[g] = |hit[g*GROUP +: GROUP];
    end
endmodule

// File: rtl/gpio_irq_port.sv
// GPIO port top: register file, address decode, registered read path,
// pad output selection and hookup of synchronizer, blink and interrupt units.
// Assumes a word-aligned byte address; unmapped addresses read zero.
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int NLINES     = 32,
    parameter int GROUP      = 8,
    parameter int ADDR_W     = 8,
    parameter int MASK_OFS   = 0,
    parameter int BLINK_HALF = 10_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NLINES-1:0]       bus_wdata,
    output logic [NLINES-1:0]       bus_rdata,
    input  logic [NLINES-1:0]       pin_in,
    output logic [NLINES-1:0]       pin_out,
    output logic [NLINES-1:0]       pin_oe,
    output logic [NLINES/GROUP-1:0] irq_group
);
    localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFS_BLINK);
    localparam logic [ADDR_W-1:0] A_INV   = ADDR_W'(OFS_INV);
    localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(OFS_EMASK + MASK_OFS);
    localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(OFS_LMASK + MASK_OFS);

    logic [NLINES-1:0] out_q, dir_q, blink_q, inv_q, emask_q, lmask_q;
    logic [NLINES-1:0] pin_sync, din, cause, rd_mux;
    logic              phase;

    gpio_sync #(.WIDTH(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst_n(rst_n), .phase(phase)
    );

    gpio_irq_unit #(.NLINES(NLINES), .GROUP(GROUP)) u_irq (
        .clk(clk), .rst_n(rst_n), .din(din),
        .level_mask(lmask_q), .edge_mask(emask_q),
        .cause_wr(bus_wr && bus_addr == A_CAUSE), .cause_wdata(bus_wdata),
        .cause(cause), .irq_group(irq_group)
    );

    // Polarity-corrected input word.
    always_comb din = pin_sync ^ inv_q;

    // Writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '0;
            blink_q <= '0;
            inv_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_OUT)   out_q   <= bus_wdata;
            if (bus_addr == A_DIR)   dir_q   <= bus_wdata;
            if (bus_addr == A_BLINK) blink_q <= bus_wdata;
            if (bus_addr == A_INV)   inv_q   <= bus_wdata;
            if (bus_addr == A_EMASK) emask_q <= bus_wdata;
            if (bus_addr == A_LMASK) lmask_q <= bus_wdata;
        end
    end

    // Read data selection by address.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_OUT)   rd_mux = out_q;
        if (bus_addr == A_DIR)   rd_mux = dir_q;
        if (bus_addr == A_BLINK) rd_mux = blink_q;
        if (bus_addr == A_INV)   rd_mux = inv_q;
        if (bus_addr == A_DIN)   rd_mux = din;
        if (bus_addr == A_CAUSE) rd_mux = cause;
        if (bus_addr == A_EMASK) rd_mux = emask_q;
        if (bus_addr == A_LMASK) rd_mux = lmask_q;
    end

    // Registered read port, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // Pad driver enable and output value selection.
    always_comb pin_oe  = ~dir_q;
    always_comb pin_out = (blink_q & {NLINES{phase}}) | (~blink_q & out_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Assertion checker for gpio_irq_port, attached by bind below.
// Observes bus ports, pad enables and the interrupt unit's registers.
module gpio_irq_port_chk
    import gpio_pkg::*;
#(
    parameter int NLINES   = 32,
    parameter int GROUP    = 8,
    parameter int ADDR_W   = 8,
    parameter int MASK_OFS = 0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [NLINES-1:0]       bus_wdata,
    input logic [NLINES-1:0]       bus_rdata,
    input logic [NLINES-1:0]       pin_oe,
    input logic [NLINES/GROUP-1:0] irq_group,
    input logic [NLINES-1:0]       cause,
    input logic [NLINES-1:0]       emask,
    input logic [NLINES-1:0]       lmask
);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);

    // R2: read data only changes in response to a read
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R3: a direction write sets pad enables to its inverse
    p_dir_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR) |=> pin_oe == ~$past(bus_wdata));

    // R7: without a cause write, no set cause bit is lost
    p_cause_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_CAUSE) |=> (cause & $past(cause)) == $past(cause));

    // R9: with both masks zero, no summary interrupt is raised
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (emask == '0 && lmask == '0) |-> irq_group == '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .NLINES(NLINES), .GROUP(GROUP), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_oe(pin_oe), .irq_group(irq_group), .cause(cause),
    .emask(emask_q), .lmask(lmask_q)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 32;
    localparam int AW   = 8;
    localparam int MOFS = 'h20;
    localparam int HALF = 4;
    localparam logic [AW-1:0] A_EM = AW'('h18 + MOFS);
    localparam logic [AW-1:0] A_LM = AW'('h1C + MOFS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0, pin_in = '0;
    logic [N-1:0]  bus_rdata, pin_out, pin_oe;
    logic [3:0]    irq_group;
    int checks = 0, failures = 0;
    bit done = 0;

    gpio_irq_port #(.NLINES(N), .GROUP(8), .ADDR_W(AW), .MASK_OFS(MOFS),
                    .BLINK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_group(irq_group)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [N-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] d;
        logic [N-1:0] held;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", pin_oe, '1);
        check("R1 out", pin_out, '0);
        check("R1 irq", {28'd0, irq_group}, '0);
        for (int a = 0; a < 'h40; a += 4) begin
            rd(AW'(a), d);
            check("R1 reg", d, '0);
        end

        // R2: read-back and latency
        wr(8'h00, 32'h1234_5678);
        wr(8'h0C, 32'h0000_0000);
        wr(A_EM, 32'hCAFE_0001);
        wr(A_LM, 32'h0000_0000);
        rd(8'h00, d); check("R2 out readback", d, 32'h1234_5678);
        rd(A_EM, d);  check("R2 emask readback", d, 32'hCAFE_0001);
        held = bus_rdata;
        idle(3);
        check("R2 rdata held", bus_rdata, held);
        wr(A_EM, '0);

        // R10: nominal mask addresses are unmapped at this offset
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h18, d); check("R10 unmapped", d, '0);
        rd(A_LM, d);  check("R10 lmask untouched", d, '0);
        rd(A_EM, d);  check("R10 emask untouched", d, '0);

        // R3: direction and output latch
        wr(8'h04, 32'hA5A5_A5A5);
        check("R3 oe", pin_oe, 32'h5A5A_5A5A);
        check("R3 out", pin_out, 32'h1234_5678);
        wr(8'h04, '0);

        // R4 and R8: sweep every line; R9 group mapping
        wr(A_LM, '1);
        for (int i = 0; i < N; i++) begin
            pin_in = 32'd1 << i;
            idle(3);
            check("R8 R9 level group", {28'd0, irq_group}, 32'd1 << (i / 8));
            rd(8'h10, d);
            check("R4 din", d, 32'd1 << i);
        end
        pin_in = '0;
        wr(A_LM, '0);
        idle(3);

        // R4: inversion and ignored writes
        pin_in = 32'h0F0F_0F0F;
        wr(8'h0C, 32'hFFFF_0000);
        idle(3);
        wr(8'h10, 32'h1111_1111);
        rd(8'h10, d); check("R4 inverted din", d, 32'hF0F0_0F0F);
        pin_in = '0;
        idle(3);

        // R6: rising on lower half, falling on upper half
        wr(8'h14, '0);
        rd(8'h14, d); check("R7 cleared", d, '0);
        pin_in = '1;
        idle(4);
        rd(8'h14, d); check("R6 rising", d, 32'h0000_FFFF);
        pin_in = '0;
        idle(4);
        rd(8'h14, d); check("R6 falling via inversion", d, 32'hFFFF_FFFF);

        // R7: write of ones keeps, zeros clear
        wr(8'h14, 32'hFF00_FF00);
        rd(8'h14, d); check("R7 partial clear", d, 32'hFF00_FF00);

        // R9: edge contribution reaches only its group
        wr(A_EM, 32'h0000_0100);
        check("R9 edge group", {28'd0, irq_group}, 32'h2);
        wr(A_EM, 32'h0000_0001);
        check("R9 masked edge", {28'd0, irq_group}, 32'h0);
        wr(A_EM, '0);
        wr(8'h14, '0);
        wr(8'h0C, '0);
        idle(3);
        wr(8'h14, '0);
        rd(8'h14, d); check("R7 all clear", d, '0);

        // R7: transition and clearing write at the same edge
        pin_in = 32'h8;
        @(negedge clk); @(negedge clk);
        wr(8'h14, '0);
        rd(8'h14, d); check("R7 edge wins", d, 32'h8);
        pin_in = '0;

        // R5: blink on line 0, line 1 follows its latch
        wr(8'h00, 32'h3);
        wr(8'h08, 32'h1);
        begin
            logic prev_b;
            int   last_t;
            int   n_tog;
            prev_b = pin_out[0];
            last_t = -1;
            n_tog = 0;
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                check("R5 non-blink line", {31'd0, pin_out[1]}, 32'd1);
                if (pin_out[0] != prev_b) begin
                    if (last_t >= 0) check("R5 half period", t - last_t, HALF);
                    last_t = t;
                    n_tog++;
                    prev_b = pin_out[0];
                end
            end
            check("R5 toggles seen", (n_tog >= 8) ? 32'd1 : 32'd0, 32'd1);
        end
        wr(8'h08, '0);
        check("R5 blink off", pin_out, 32'h3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule